// File: doc/BRIEF.md
# Quarter-Track Seek Sequencer

This block moves the head of a four-phase stepper positioner from the track a drive last sat on to a newly requested track. A controller picks a drive, presents a target track and a density flag, and pulses `start`. The block maps both tracks onto a quarter-track position grid, using a multiplier of 4 or 3 chosen by the density flag. It then walks the head one grid position at a time. Each move energizes one phase, or two neighbouring phases, for a fixed number of timebase units. All phases are then released for a longer settle interval, and the block compares positions again.

All timing is counted in units of an external 100 us `tick`, so the clock frequency does not matter. A small per-drive store remembers the last track of each drive, and a global register holds the most recently requested track. While a seek is running, every tick is also passed on as a pulse and accumulated in a free-running elapsed-time counter, which motor spin-up bookkeeping elsewhere can use. A seek whose start and end positions match finishes without touching the phases.

Top module: `qtrack_seek`

## Requirements
- R1: After synchronous reset, `phase` is 0000, `busy`, `done` and `unit_pulse` are 0, `elapsed` is 0, `last_track` is 0 and every drive's stored track reads 0.
- R2: The head position of a track is track×4 when `quad_step` is 1 and track×3 when it is 0. The same factor converts both the stored current track and the target, so a seek takes exactly |pos(target) − pos(current)| steps.
- R3: Each step moves the position by exactly one toward the target, and the seek ends when the position equals the target position.
- R4: While energized, `phase` bit k drives phase k. Let idx be position bits [2:1]. An even position sets only bit idx. An odd position sets bits idx and (idx+1) mod 4.
- R5: Each step holds its phase pattern for ON_TICKS (default 48) ticks. All phases are then off for OFF_TICKS (default 112) ticks plus one compare cycle before the next step is energized.
- R6: A `start` accepted while idle writes `target_track` into the stored track of the drive on `drive_sel` and into `last_track`, visible one cycle later. Other drives' stored tracks are unchanged.
- R7: `phase` is 0000 whenever the block is idle and during every settle interval.
- R8: `done` is a single-cycle pulse in the cycle after the final compare, when `busy` has just fallen. A zero-length seek raises `done` two cycles after `start` with no phase activity.
- R9: `elapsed` (16 bits, wrapping) increments once for every cycle in which `busy` and `tick` are both 1. `unit_pulse` is 1 exactly in those cycles.
- R10: `start` while `busy` is ignored. The target, the stored tracks and `last_track` are unchanged.
- R11: Energize and settle intervals advance only on `tick`. With `tick` held at 0, the energized pattern stays on indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Seek request strobe, taken only while idle |
| drive_sel | input | DSEL_W (1) | Drive whose stored track is read and updated |
| target_track | input | TRACK_W (8) | Requested track |
| quad_step | input | 1 | Density flag: 1 selects ×4, 0 selects ×3 |
| tick | input | 1 | 100 us timebase strobe |
| phase | output | 4 | Phase enables, bit k drives phase k |
| busy | output | 1 | Seek in progress |
| done | output | 1 | One-cycle completion pulse |
| unit_pulse | output | 1 | Tick forwarded while busy |
| elapsed | output | ELAPSED_W (16) | Busy-time counter in tick units |
| drive_track | output | TRACK_W (8) | Stored track of the drive on `drive_sel` |
| last_track | output | TRACK_W (8) | Most recently requested track |

## Verification
The assertions assume that `drive_sel`, `target_track` and `quad_step` matter only in the cycle `start` is high while idle, and that reset is applied before the first seek. The stimulus changes those inputs only at falling edges, next to a `start` pulse. `tick` is held high for most runs, so interval lengths can be measured in cycles. One run holds `tick` low for hundreds of cycles to show that the timers are frozen. Position mismatches are chosen to cover both directions, both multipliers, odd positions, wrap from phase 3 to phase 0, and a zero-length seek.

// File: rtl/qs_pkg.sv
package qs_pkg;
    localparam int TRACK_W   = 8;
    localparam int POS_W     = TRACK_W + 2;
    localparam int NPHASE    = 4;
    localparam int LIMIT_W   = 8;

    typedef logic [TRACK_W-1:0] track_t;
    typedef logic [POS_W-1:0]   pos_t;
    typedef logic [NPHASE-1:0]  phase_t;

    typedef enum logic [1:0] {
        SK_IDLE = 2'd0,
        SK_EVAL = 2'd1,
        SK_ON   = 2'd2,
        SK_OFF  = 2'd3
    } seek_state_e;

    // Track to quarter-grid position: x4 (quad) or x3
    function automatic pos_t to_qpos(input track_t trk, input logic quad);
        pos_t wide;
        wide = {2'b00, trk};
        if (quad) return {trk, 2'b00};
        return pos_t'({1'b0, trk, 1'b0} + wide);
    endfunction

    // Phase pattern for a grid position
    function automatic phase_t phase_of(input pos_t p);
        phase_t base;
        base = phase_t'(1) << p[2:1];
        if (p[0]) return base | {base[NPHASE-2:0], base[NPHASE-1]};
        return base;
    endfunction
endpackage

// File: rtl/qs_track_file.sv
module qs_track_file #(
    parameter int DRIVES  = 2,
    parameter int TRACK_W = 8,
    localparam int DSEL_W = (DRIVES > 1) ? $clog2(DRIVES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [DSEL_W-1:0]  sel,
    input  logic [TRACK_W-1:0] wdata,
    output logic [TRACK_W-1:0] rdata
);
    logic [TRACK_W-1:0] mem [DRIVES];

    for (genvar gi = 0; gi < DRIVES; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[gi] <= '0;
            else if (we && sel == DSEL_W'(gi))
                mem[gi] <= wdata;
        end
    end

    assign rdata = mem[sel];
endmodule

// File: rtl/qs_dwell_timer.sv
module qs_dwell_timer #(
    parameter int LIMIT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               clear,
    input  logic               tick,
    input  logic [LIMIT_W-1:0] limit,
    output logic               expire
);
    logic [LIMIT_W-1:0] cnt;

    assign expire = en && tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (en && tick)
            cnt <= cnt + 1'b1;
    end

    AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (rst)
        en |-> cnt < limit) else $error("dwell count overran"); // R5
    AST_DWELL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (en && !tick && !clear) |=> $stable(cnt)) else $error("dwell moved without tick"); // R11
endmodule

// File: rtl/qs_elapsed_ctr.sv
module qs_elapsed_ctr #(
    parameter int ELAPSED_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 tick,
    output logic                 pulse,
    output logic [ELAPSED_W-1:0] count
);
    assign pulse = en && tick;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (pulse)
            count <= count + 1'b1;
    end

    AST_ELAPSED_INC: assert property (@(posedge clk) disable iff (rst)
        (en && tick) |=> count == $past(count) + 1'b1) else $error("elapsed missed a tick"); // R9
    AST_ELAPSED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(en && tick) |=> $stable(count)) else $error("elapsed moved while quiet"); // R9
endmodule

// File: rtl/qtrack_seek.sv
module qtrack_seek
    import qs_pkg::*;
#(
    parameter int DRIVES    = 2,
    parameter int ON_TICKS  = 48,
    parameter int OFF_TICKS = 112,
    parameter int ELAPSED_W = 16,
    localparam int DSEL_W   = (DRIVES > 1) ? $clog2(DRIVES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [DSEL_W-1:0]    drive_sel,
    input  logic [TRACK_W-1:0]   target_track,
    input  logic                 quad_step,
    input  logic                 tick,
    output logic [NPHASE-1:0]    phase,
    output logic                 busy,
    output logic                 done,
    output logic                 unit_pulse,
    output logic [ELAPSED_W-1:0] elapsed,
    output logic [TRACK_W-1:0]   drive_track,
    output logic [TRACK_W-1:0]   last_track
);
    localparam logic [LIMIT_W-1:0] ON_LIM  = LIMIT_W'(ON_TICKS);
    localparam logic [LIMIT_W-1:0] OFF_LIM = LIMIT_W'(OFF_TICKS);

    seek_state_e state;
    pos_t        cur_pos, tgt_pos;
    track_t      last_q;
    logic        done_q;
    logic        accept, dwell_exp, dwell_en, dwell_clr;
    logic [LIMIT_W-1:0] dwell_lim;
    track_t      stored_trk;

    assign accept = (state == SK_IDLE) && start;

    qs_track_file #(.DRIVES(DRIVES), .TRACK_W(TRACK_W)) u_tracks (
        .clk   (clk),
        .rst   (rst),
        .we    (accept),
        .sel   (drive_sel),
        .wdata (target_track),
        .rdata (stored_trk)
    );

    assign dwell_en  = (state == SK_ON) || (state == SK_OFF);
    assign dwell_clr = (state == SK_EVAL) || dwell_exp;
    assign dwell_lim = (state == SK_ON) ? ON_LIM : OFF_LIM;

    qs_dwell_timer #(.LIMIT_W(LIMIT_W)) u_dwell (
        .clk    (clk),
        .rst    (rst),
        .en     (dwell_en),
        .clear  (dwell_clr),
        .tick   (tick),
        .limit  (dwell_lim),
        .expire (dwell_exp)
    );

    qs_elapsed_ctr #(.ELAPSED_W(ELAPSED_W)) u_elapsed (
        .clk   (clk),
        .rst   (rst),
        .en    (busy),
        .tick  (tick),
        .pulse (unit_pulse),
        .count (elapsed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SK_IDLE;
            cur_pos <= '0;
            tgt_pos <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                SK_IDLE: begin
                    if (start) begin
                        cur_pos <= to_qpos(stored_trk, quad_step);
                        tgt_pos <= to_qpos(target_track, quad_step);
                        last_q  <= target_track;
                        state   <= SK_EVAL;
                    end
                end
                SK_EVAL: begin
                    if (cur_pos == tgt_pos) begin
                        done_q <= 1'b1;
                        state  <= SK_IDLE;
                    end else begin
                        cur_pos <= (tgt_pos > cur_pos) ? cur_pos + 1'b1 : cur_pos - 1'b1;
                        state   <= SK_ON;
                    end
                end
                SK_ON:  if (dwell_exp) state <= SK_OFF;
                SK_OFF: if (dwell_exp) state <= SK_EVAL;
                default: state <= SK_IDLE;
            endcase
        end
    end

    assign busy        = (state != SK_IDLE);
    assign done        = done_q;
    assign phase       = (state == SK_ON) ? phase_of(cur_pos) : '0;
    assign drive_track = stored_trk;
    assign last_track  = last_q;

    AST_IDLE_PHASE_OFF: assert property (@(posedge clk) disable iff (rst)
        !busy |-> phase == '0) else $error("phase active while idle"); // R7
    AST_PHASE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        phase != '0 |-> ($countones(phase) == 1 || phase == 4'b0011 || phase == 4'b0110 ||
                         phase == 4'b1100 || phase == 4'b1001)) else $error("bad phase pattern"); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done held"); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("done while busy"); // R8
    AST_STEP_UNIT: assert property (@(posedge clk) disable iff (rst)
        (state == SK_EVAL && cur_pos != tgt_pos) |=>
            (cur_pos == pos_t'($past(cur_pos) + 1'b1) || cur_pos == pos_t'($past(cur_pos) - 1'b1)))
        else $error("step not unit"); // R3
    AST_START_LATCH: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> last_track == $past(target_track)) else $error("start not latched"); // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(last_track)) else $error("start taken while busy"); // R10
endmodule

// File: tb/qtrack_seek_bench.sv
module qtrack_seek_bench;
    localparam int ON  = 48;
    localparam int OFF = 112;
    localparam int STEP_CYC = ON + OFF + 1;
    localparam int NV = 7;
    // {drive, quad, target[7:0], expected steps[7:0], last phase[3:0]}
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'd2, 8'd8, 4'b0001},
        {1'b0, 1'b1, 8'd1, 8'd4, 4'b0100},
        {1'b1, 1'b0, 8'd3, 8'd9, 4'b0011},
        {1'b1, 1'b0, 8'd2, 8'd3, 4'b1000},
        {1'b0, 1'b0, 8'd1, 8'd0, 4'b0000},
        {1'b1, 1'b1, 8'd3, 8'd4, 4'b0100},
        {1'b0, 1'b1, 8'd0, 8'd4, 4'b0001}
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, quad_step = 1'b0, tick = 1'b1;
    logic [0:0] drive_sel = '0;
    logic [7:0] target_track = '0;
    logic [3:0] phase;
    logic busy, done, unit_pulse;
    logic [15:0] elapsed;
    logic [7:0] drive_track, last_track;

    int checks = 0, errors = 0, cyc = 0;
    int trk_m [2];

    always #4 clk = ~clk;

    qtrack_seek u_qtrack_seek (
        .clk(clk), .rst(rst), .start(start), .drive_sel(drive_sel),
        .target_track(target_track), .quad_step(quad_step), .tick(tick),
        .phase(phase), .busy(busy), .done(done), .unit_pulse(unit_pulse),
        .elapsed(elapsed), .drive_track(drive_track), .last_track(last_track)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int qp(input int t, input bit quad);
        return quad ? t * 4 : t * 3;
    endfunction

    function automatic logic [3:0] qdec(input int p);
        int idx;
        logic [3:0] m;
        idx = (p >> 1) & 3;
        m = 4'b0001 << idx;
        if (p % 2 == 1) m = m | (4'b0001 << ((idx + 1) % 4));
        return m;
    endfunction

    task automatic run_seek(input int drv, input bit quad, input int tgt,
                            output int wins, output logic [3:0] lastph, output int dt);
        int e0, gap, onl, pos, tpos;
        logic [3:0] prev;
        bit seen;
        e0 = int'(elapsed);
        pos = qp(trk_m[drv], quad);
        tpos = qp(tgt, quad);
        @(negedge clk);
        drive_sel = 1'(drv); quad_step = quad; target_track = 8'(tgt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(drive_track == 8'(tgt), "R6", "stored track after start", drive_track, tgt);
        chk(last_track == 8'(tgt), "R6", "last_track after start", last_track, tgt);
        prev = '0; wins = 0; gap = 0; onl = 0; seen = 0; lastph = '0;
        for (int k = 0; k < 60000 && !seen; k++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
            end else if (phase != '0) begin
                if (prev == '0) begin
                    wins++;
                    if (wins > 1) chk(gap == OFF + 1, "R5", "settle gap cycles", gap, OFF + 1);
                    pos += (tpos > pos) ? 1 : -1;
                    chk(phase == qdec(pos), "R4", "phase pattern", phase, qdec(pos));
                    onl = 0;
                end
                onl++;
                lastph = phase;
            end else begin
                if (prev != '0) begin
                    chk(onl == ON, "R5", "energize cycles", onl, ON);
                    gap = 0;
                end
                gap++;
            end
            prev = phase;
        end
        chk(seen, "R8", "done seen", seen, 1);
        chk(!busy, "R8", "busy low at done", busy, 0);
        chk(pos == tpos, "R3", "final position", pos, tpos);
        dt = int'(elapsed) - e0;
        @(negedge clk);
        chk(!done, "R8", "done one cycle", done, 0);
        trk_m[drv] = tgt;
    endtask

    initial begin
        int w, dt, e0;
        logic [3:0] lp;
        trk_m[0] = 0; trk_m[1] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(phase == '0, "R1", "phase", phase, 0);
        chk(!busy && !done && !unit_pulse, "R1", "busy/done/pulse", {busy, done, unit_pulse}, 0);
        chk(elapsed == '0, "R1", "elapsed", elapsed, 0);
        chk(last_track == '0, "R1", "last_track", last_track, 0);
        drive_sel = 1'b1;
        @(negedge clk);
        chk(drive_track == '0, "R1", "drive 1 track", drive_track, 0);
        chk(phase == '0, "R7", "idle phase", phase, 0);

        for (int v = 0; v < NV; v++) begin
            run_seek(int'(VEC[v][21]), VEC[v][20], int'(VEC[v][19:12]), w, lp, dt);
            chk(w == int'(VEC[v][11:4]), "R2", "step count", w, VEC[v][11:4]);
            chk(lp == VEC[v][3:0], "R4", "last phase", lp, VEC[v][3:0]);
            chk(dt == w * STEP_CYC + 1, "R9", "elapsed delta", dt, w * STEP_CYC + 1);
            if (w == 0) chk(lp == '0, "R8", "zero seek phase activity", lp, 0);
        end

        // R6 other drive untouched
        @(negedge clk); drive_sel = 1'b1;
        @(negedge clk);
        chk(drive_track == 8'(trk_m[1]), "R6", "drive 1 kept", drive_track, trk_m[1]);

        // R10 start while busy ignored
        @(negedge clk);
        drive_sel = 1'b0; quad_step = 1'b1; target_track = 8'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        drive_sel = 1'b1; target_track = 8'd7; quad_step = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(last_track == 8'd1, "R10", "last_track during busy start", last_track, 1);
        chk(drive_track == 8'(trk_m[1]), "R10", "drive 1 during busy start", drive_track, trk_m[1]);
        for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
        chk(done, "R10", "original seek completes", done, 1);
        @(negedge clk);
        chk(drive_track == 8'(trk_m[1]), "R10", "drive 1 after seek", drive_track, trk_m[1]);
        drive_sel = 1'b0;
        @(negedge clk);
        chk(drive_track == 8'd1, "R10", "drive 0 after seek", drive_track, 1);
        chk(last_track == 8'd1, "R10", "last_track after seek", last_track, 1);
        trk_m[0] = 1;

        // R11 tick held low freezes the energized pattern (drive 1: 3 -> 4, x3: pos 9 -> 12)
        e0 = int'(elapsed);
        tick = 1'b0;
        drive_sel = 1'b1; quad_step = 1'b0; target_track = 8'd4; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (300) @(negedge clk);
        chk(busy, "R11", "busy while tick low", busy, 1);
        chk(phase == qdec(10), "R11", "phase frozen", phase, qdec(10));
        chk(int'(elapsed) == e0, "R9", "elapsed frozen without tick", elapsed, e0);
        chk(!unit_pulse, "R9", "no pulse without tick", unit_pulse, 0);
        tick = 1'b1;
        @(negedge clk);
        chk(unit_pulse, "R9", "pulse with tick while busy", unit_pulse, 1);
        for (int k = 0; k < 2000 && !done; k++) @(negedge clk);
        chk(done, "R11", "seek completes after tick resumes", done, 1);
        chk(int'(elapsed) - e0 == 3 * STEP_CYC, "R9", "elapsed after hold",
            int'(elapsed) - e0, 3 * STEP_CYC);
        @(negedge clk);
        chk(!unit_pulse && phase == '0, "R7", "idle after hold seek", {unit_pulse, phase}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule